// File: doc/BRIEF.md
# Dual-Window Multiplicity Trigger

This block forms a first-level trigger decision from a stream of detector multiplicity values, where each value is the count of channels hit in one fixed sampling period (a "bucket", one new value every 40 ns). Two conditions are evaluated side by side. Each condition has its own multiplicity threshold and its own bucket count. A condition is met once the multiplicity has stayed at or above its threshold for at least that many consecutive valid samples. A typical setup pairs a tight, short window with a loose, long one, for example a threshold of 6 held for 3 buckets together with a threshold of 3 held for 6 buckets.

A two-bit rule select combines the two condition results into the final decision: low only, high only, either, or both. When the selected rule is satisfied, the block emits a one-clock accept pulse and clears both run counters, so a single sustained burst produces one trigger and the next one has to build its run up from zero again. An enable input holds the whole block idle.

Top module: `mult_l1_trigger`

## Requirements
- R1: On each clock with `mult_valid_i` high and `enable_i` high, a condition's run length increases by one when `mult_i` is greater than or equal to its threshold (equality counts) and drops to zero when `mult_i` is below it. Cycles with `mult_valid_i` low leave the run unchanged, whatever `mult_i` holds.
- R2: `lo_ok_o` and `hi_ok_o` are levels. Each is high while its own run length is at least its bucket count. The two conditions are independent of each other and of the rule select.
- R3: A bucket count of zero forces that condition's OK output low, and the condition can then never satisfy a rule that needs it.
- R4: `mode_i` picks the rule. 2'b00 uses the low condition only, 2'b01 the high condition only, 2'b10 accepts on low OR high, and 2'b11 accepts on low AND high.
- R5: A met condition stays met while its run continues, including beyond its bucket count. The AND rule therefore fires in the first cycle in which both runs are long enough at the same time, and never fires if one run is broken before the other completes.
- R6: `l1_ok_o` is a single-cycle pulse. It rises on the clock edge that follows the cycle in which the selected rule is satisfied. On that same edge both run lengths are cleared to zero, so `lo_ok_o` and `hi_ok_o` are low while the pulse is high.
- R7: While `enable_i` is low, `lo_ok_o`, `hi_ok_o` and `l1_ok_o` stay low, samples are ignored, and runs start from zero once the block is enabled again.
- R8: A run length saturates at 2^NB_W-1 (15 by default) and does not wrap. With a bucket count of 15, a condition stays met for every further sample of an unbroken run.
- R9: While `rst_ni` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Block enable |
| mult_valid_i | input | 1 | Strobe marking a new multiplicity sample |
| mult_i | input | MULT_W (11) | Hit-channel count, 0 to 1024 |
| lo_thresh_i | input | MULT_W | Low-condition threshold |
| lo_buckets_i | input | NB_W (4) | Low-condition required run, 0 = off |
| hi_thresh_i | input | MULT_W | High-condition threshold |
| hi_buckets_i | input | NB_W | High-condition required run, 0 = off |
| mode_i | input | 2 | Combination rule: 00 low, 01 high, 10 OR, 11 AND |
| lo_ok_o | output | 1 | Low condition met |
| hi_ok_o | output | 1 | High condition met |
| l1_ok_o | output | 1 | Final accept pulse |

## Verification
The assertions assume that thresholds, bucket counts and the rule select are held steady while a run is building. They also assume that `mult_valid_i` is a clean one-cycle strobe, so the increment and saturation properties can compare each run length only with its value one clock earlier. The stimulus sets every configuration input while the block is disabled, issues each sample as a single valid cycle followed by idle cycles, and drives the multiplicity bus to zero during those idle cycles. This way every idle cycle would break a run if non-valid cycles were not ignored.

// File: rtl/mlt_pkg.sv
package mlt_pkg;
  typedef enum logic [1:0] {
    CMB_LOW  = 2'b00,
    CMB_HIGH = 2'b01,
    CMB_OR   = 2'b10,
    CMB_AND  = 2'b11
  } cmb_mode_e;

  localparam int NCOND  = 2;
  localparam int IDX_LO = 0;
  localparam int IDX_HI = 1;
endpackage

// File: rtl/mlt_run_counter.sv
module mlt_run_counter #(
  parameter int MULT_W = 11,
  parameter int NB_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              valid_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [MULT_W-1:0] thresh_i,
  input  logic [NB_W-1:0]   buckets_i,
  output logic              ok_o
);
  localparam logic [NB_W-1:0] CNT_MAX = '1;

  logic [NB_W-1:0] run_q;
  logic            above;

  assign above = (mult_i >= thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                run_q <= '0;
    else if (clr_i || !en_i)    run_q <= '0;
    else if (valid_i) begin
      if (!above)               run_q <= '0;
      else if (run_q != CNT_MAX) run_q <= run_q + 1'b1;
    end
  end

  // zero bucket count disables the condition
  assign ok_o = en_i && (buckets_i != '0) && (run_q >= buckets_i);

  assert_run_break_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && valid_i && !above) |=> (run_q == '0));

  assert_run_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && valid_i && above && run_q != CNT_MAX) |=> (run_q == $past(run_q) + 1'b1));

  assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && !valid_i) |=> $stable(run_q));

  assert_saturate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && run_q == CNT_MAX && !(valid_i && !above)) |=> (run_q == CNT_MAX));
endmodule

// File: rtl/mlt_combine.sv
module mlt_combine
  import mlt_pkg::*;
(
  input  cmb_mode_e mode_i,
  input  logic      lo_i,
  input  logic      hi_i,
  output logic      sel_o
);
  always_comb begin
    unique case (mode_i)
      CMB_LOW:  sel_o = lo_i;
      CMB_HIGH: sel_o = hi_i;
      CMB_OR:   sel_o = lo_i | hi_i;
      CMB_AND:  sel_o = lo_i & hi_i;
      default:  sel_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mult_l1_trigger.sv
module mult_l1_trigger
  import mlt_pkg::*;
#(
  parameter int MULT_W = 11,
  parameter int NB_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              mult_valid_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [MULT_W-1:0] lo_thresh_i,
  input  logic [NB_W-1:0]   lo_buckets_i,
  input  logic [MULT_W-1:0] hi_thresh_i,
  input  logic [NB_W-1:0]   hi_buckets_i,
  input  logic [1:0]        mode_i,
  output logic              lo_ok_o,
  output logic              hi_ok_o,
  output logic              l1_ok_o
);
  logic [NCOND-1:0][MULT_W-1:0] thr;
  logic [NCOND-1:0][NB_W-1:0]   nb;
  logic [NCOND-1:0]             ok;
  logic                         sel;
  logic                         fire;
  logic                         l1_q;

  assign thr[IDX_LO] = lo_thresh_i;
  assign thr[IDX_HI] = hi_thresh_i;
  assign nb[IDX_LO]  = lo_buckets_i;
  assign nb[IDX_HI]  = hi_buckets_i;

  for (genvar g = 0; g < NCOND; g++) begin : g_cond
    mlt_run_counter #(
      .MULT_W(MULT_W),
      .NB_W  (NB_W)
    ) u_run (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (enable_i),
      .clr_i    (fire),
      .valid_i  (mult_valid_i),
      .mult_i   (mult_i),
      .thresh_i (thr[g]),
      .buckets_i(nb[g]),
      .ok_o     (ok[g])
    );
  end

  mlt_combine u_cmb (
    .mode_i(cmb_mode_e'(mode_i)),
    .lo_i  (ok[IDX_LO]),
    .hi_i  (ok[IDX_HI]),
    .sel_o (sel)
  );

  // fire clears the runs on the same edge that raises the pulse
  assign fire = enable_i & sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) l1_q <= 1'b0;
    else         l1_q <= fire;
  end

  assign lo_ok_o = ok[IDX_LO];
  assign hi_ok_o = ok[IDX_HI];
  assign l1_ok_o = l1_q;

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l1_ok_o |=> !l1_ok_o);

  assert_cleared_on_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l1_ok_o |-> (!lo_ok_o && !hi_ok_o));

  assert_disabled_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !l1_ok_o);

  assert_and_needs_both_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l1_ok_o && $past(mode_i) == CMB_AND) |-> ($past(lo_ok_o) && $past(hi_ok_o)));

  assert_zero_bucket_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_buckets_i == '0 && $past(hi_buckets_i) == '0 && $past(mode_i) == CMB_HIGH) |-> !l1_ok_o);
endmodule

// File: tb/mult_l1_trigger_tb.sv
module mult_l1_trigger_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NONE = 8;

  typedef struct packed {
    logic [1:0]         mode;
    logic [10:0]        lt;
    logic [3:0]         ln;
    logic [10:0]        ht;
    logic [3:0]         hn;
    logic [0:7][10:0]   s;
    logic [3:0]         fire_idx;
  } vec_t;

  // mode: 0 low, 1 high, 2 OR, 3 AND; fire_idx = sample after which the pulse appears
  localparam vec_t VECS [10] = '{
    '{2'd2, 11'd3, 4'd6, 11'd6, 4'd3, {11'd7, 11'd7, 11'd7, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0}, 4'd2},
    '{2'd0, 11'd3, 4'd6, 11'd6, 4'd3, {11'd4, 11'd4, 11'd4, 11'd4, 11'd4, 11'd4, 11'd0, 11'd0}, 4'd5},
    '{2'd1, 11'd3, 4'd6, 11'd6, 4'd3, {11'd4, 11'd4, 11'd4, 11'd4, 11'd4, 11'd4, 11'd0, 11'd0}, 4'd8},
    '{2'd1, 11'd3, 4'd6, 11'd6, 4'd3, {11'd6, 11'd6, 11'd5, 11'd6, 11'd6, 11'd6, 11'd0, 11'd0}, 4'd5},
    '{2'd3, 11'd3, 4'd6, 11'd6, 4'd3, {11'd7, 11'd7, 11'd7, 11'd7, 11'd7, 11'd7, 11'd0, 11'd0}, 4'd5},
    '{2'd3, 11'd3, 4'd6, 11'd6, 4'd3, {11'd7, 11'd7, 11'd7, 11'd4, 11'd4, 11'd4, 11'd0, 11'd0}, 4'd8},
    '{2'd0, 11'd3, 4'd6, 11'd6, 4'd3, {11'd3, 11'd3, 11'd3, 11'd2, 11'd3, 11'd3, 11'd0, 11'd0}, 4'd8},
    '{2'd2, 11'd3, 4'd0, 11'd6, 4'd3, {11'd4, 11'd4, 11'd4, 11'd4, 11'd4, 11'd4, 11'd4, 11'd4}, 4'd8},
    '{2'd0, 11'd3, 4'd1, 11'd6, 4'd3, {11'd0, 11'd0, 11'd3, 11'd0, 11'd0, 11'd0, 11'd0, 11'd0}, 4'd2},
    '{2'd2, 11'd3, 4'd6, 11'd6, 4'd3, {11'd5, 11'd5, 11'd5, 11'd5, 11'd5, 11'd5, 11'd0, 11'd0}, 4'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        valid = 1'b0;
  logic [10:0] mult = '0;
  logic [10:0] lt = '0;
  logic [3:0]  ln = '0;
  logic [10:0] ht = '0;
  logic [3:0]  hn = '0;
  logic [1:0]  mode = '0;
  logic        lo_ok, hi_ok, l1_ok;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mult_l1_trigger u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .mult_valid_i(valid), .mult_i(mult),
    .lo_thresh_i(lt), .lo_buckets_i(ln), .hi_thresh_i(ht), .hi_buckets_i(hn),
    .mode_i(mode), .lo_ok_o(lo_ok), .hi_ok_o(hi_ok), .l1_ok_o(l1_ok)
  );

  function automatic string tag_of(int i);
    case (i)
      0, 9: return "R4";
      1, 2, 6: return "R4";
      3: return "R1";
      4, 5: return "R5";
      7: return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic configure(input logic [1:0] m, input logic [10:0] l_t, input logic [3:0] l_n,
                           input logic [10:0] h_t, input logic [3:0] h_n);
    @(negedge clk);
    en = 1'b0; mode = m; lt = l_t; ln = l_n; ht = h_t; hn = h_n;
    @(negedge clk);
    en = 1'b1;
  endtask

  // one valid cycle, then idle cycles with mult driven to zero
  task automatic push(input logic [10:0] m, output logic lo, output logic hi, output logic l1);
    @(negedge clk);
    valid = 1'b1; mult = m;
    @(negedge clk);
    valid = 1'b0; mult = '0;
    lo = lo_ok; hi = hi_ok;
    @(negedge clk);
    l1 = l1_ok;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic lo, hi, l1;
    repeat (3) @(negedge clk);
    check("R9", "lo_ok in reset", lo_ok, 1'b0);
    check("R9", "hi_ok in reset", hi_ok, 1'b0);
    check("R9", "l1_ok in reset", l1_ok, 1'b0);
    rst_n = 1'b1;

    // table walk
    for (int v = 0; v < 10; v++) begin
      configure(VECS[v].mode, VECS[v].lt, VECS[v].ln, VECS[v].ht, VECS[v].hn);
      for (int i = 0; i < 8; i++) begin
        push(VECS[v].s[i], lo, hi, l1);
        check(tag_of(v), $sformatf("vec %0d sample %0d pulse", v, i), l1,
              (i == int'(VECS[v].fire_idx)) ? 1'b1 : 1'b0);
      end
    end

    // R2/R5/R1: levels independent of rule, latched while run continues, broken by low sample
    configure(2'd0, 11'd3, 4'd6, 11'd6, 4'd3);
    push(11'd7, lo, hi, l1);
    push(11'd7, lo, hi, l1);
    check("R2", "hi_ok after 2 buckets", hi, 1'b0);
    push(11'd7, lo, hi, l1);
    check("R2", "hi_ok after 3 buckets", hi, 1'b1);
    check("R2", "lo_ok after 3 buckets", lo, 1'b0);
    check("R4", "low-only ignores high", l1, 1'b0);
    push(11'd7, lo, hi, l1);
    check("R5", "hi_ok held on continued run", hi, 1'b1);
    push(11'd2, lo, hi, l1);
    check("R1", "hi_ok after break", hi, 1'b0);
    check("R1", "lo_ok after break", lo, 1'b0);

    // R8: saturation with 15-bucket window
    configure(2'd1, 11'd3, 4'd15, 11'd2047, 4'd3);
    for (int i = 0; i < 18; i++) begin
      push(11'd4, lo, hi, l1);
      check("R8", $sformatf("lo_ok run %0d", i + 1), lo, (i >= 14) ? 1'b1 : 1'b0);
    end

    // R7: disabled block ignores everything
    configure(2'd2, 11'd3, 4'd6, 11'd6, 4'd3);
    @(negedge clk); en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      push(11'd7, lo, hi, l1);
      check("R7", "hi_ok while disabled", hi, 1'b0);
      check("R7", "l1_ok while disabled", l1, 1'b0);
    end
    @(negedge clk); en = 1'b1;
    push(11'd7, lo, hi, l1);
    check("R7", "run restarts from zero", hi, 1'b0);

    // R6: pulse clears both runs, next trigger needs a full new run
    configure(2'd2, 11'd3, 4'd6, 11'd6, 4'd3);
    push(11'd7, lo, hi, l1);
    push(11'd7, lo, hi, l1);
    push(11'd7, lo, hi, l1);
    check("R6", "pulse on third bucket", l1, 1'b1);
    @(negedge clk);
    check("R6", "pulse lasts one cycle", l1_ok, 1'b0);
    push(11'd7, lo, hi, l1);
    check("R6", "hi_ok cleared after pulse", hi, 1'b0);
    push(11'd7, lo, hi, l1);
    check("R6", "no retrigger", l1, 1'b0);
    push(11'd7, lo, hi, l1);
    check("R6", "second pulse after new run", l1, 1'b1);

    // R3: zero bucket count in high-only mode
    configure(2'd1, 11'd3, 4'd6, 11'd6, 4'd0);
    for (int i = 0; i < 4; i++) begin
      push(11'd9, lo, hi, l1);
      check("R3", "hi_ok with zero buckets", hi, 1'b0);
      check("R3", "l1_ok with zero buckets", l1, 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule